// File: doc/BRIEF.md
# Lagging-Standby Dual Register Machine with Fast Recovery

This block holds two copies of a small register machine. The primary copy executes each accepted operation at once. The shadow copy executes the same operation one cycle later, so it always holds the state the primary had before its most recent operation. An external on-line checker reports a corrupted primary result through `err_i`. It may also mark the fault as persistent with `err_persist_i`. The block uses the lagging shadow in two ways: as a live backup for a fast state restore, and as a hot standby that takes over after a fault that does not go away.

On a first error the fault is assumed to be transient. The primary is reloaded from the shadow and the lost operation is executed again, which costs two busy cycles. If the error is seen again on the re-executed result, or if the checker reports the fault as persistent, the shadow becomes the active unit. The primary is then frozen and its error input is no longer used. The operation source sees back-pressure through `op_ready_o` while recovery is in progress, so no operation is lost. `upset_i` models a single-event upset: it is XORed into the value that the primary writes, and it lets a test corrupt the primary in a controlled way.

Top module: `mt_recovery`

## Requirements
- R1: After reset every register of both copies is zero, `active_sel_o`, `busy_o` and `takeover_o` are 0 and `op_ready_o` is 1.
- R2: An operation is accepted when `op_valid_i` and `op_ready_o` are both 1 at a rising edge. Code 0 does nothing. Code 1 loads the immediate into register `op_dst_i`. Code 2 adds the immediate modulo 2^W. Code 3 XORs the immediate. `state_o` shows register i of the active copy at bits [i*W +: W].
- R3: The shadow copy applies every accepted operation exactly one cycle after the primary. After a takeover, `state_o` therefore equals the result of every accepted operation, including the one in flight when the error arrived.
- R4: When `err_i` is 1 with `err_persist_i` 0 in normal operation, `busy_o` is 1 for exactly the next two cycles. The primary is reloaded from the shadow and the last operation is replayed. In the first cycle after `busy_o` drops, `state_o` equals the error-free result.
- R5: `op_ready_o` is 0 in the cycle in which `err_i` is raised during normal operation and in both busy cycles. Operations held by the source during that time are accepted afterwards, in order.
- R6: When `err_i` is 1 in the second busy cycle, the fault is treated as permanent and `takeover_o` becomes 1 in the next cycle. This is at most three cycles after the first error.
- R7: When `err_i` and `err_persist_i` are both 1 in normal operation, `takeover_o` becomes 1 in the next cycle and `busy_o` stays 0.
- R8: Once `takeover_o` is 1, it and `active_sel_o` stay 1 until reset. `err_i` and `upset_i` then have no effect: `op_ready_o` stays 1, `busy_o` stays 0, and `state_o` follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_code_i | input | 2 | Operation code (R2) |
| op_dst_i | input | $clog2(NREG) | Destination register index |
| op_imm_i | input | W | Immediate operand |
| op_ready_o | output | 1 | Operation can be accepted this cycle |
| err_i | input | 1 | Checker flags the primary's state as corrupt |
| err_persist_i | input | 1 | Checker marks the flagged fault as persistent |
| upset_i | input | W | Bit-flip mask XORed into the primary's write data |
| active_sel_o | output | 1 | 0: primary drives state_o, 1: shadow does |
| state_o | output | NREG*W | Registers of the active copy |
| busy_o | output | 1 | Restore or replay in progress |
| takeover_o | output | 1 | Shadow has permanently taken over |

## Verification
The bench builds the block with W = 8 and NREG = 4. The narrow width makes additions wrap often. The four registers mean the replayed operation often targets a register that earlier corrupted writes also hit, so a wrong restore source shows up in `state_o`. Each test episode ends in a reset, and takeover is sticky, so the bench runs many short episodes. Recurrence, persistent faults and ignored upsets after takeover are each reached many times.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_LDI  = 2'd1,
    OP_ADDI = 2'd2,
    OP_XORI = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MD_RUN    = 2'd0,
    MD_REPLAY = 2'd1,
    MD_VERIFY = 2'd2,
    MD_TAKEN  = 2'd3
  } mode_e;
endpackage

// File: rtl/mt_regbank.sv
module mt_regbank #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              load_i,
  input  logic [NREG*W-1:0] load_data_i,
  output logic [NREG*W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (load_i)                              q <= load_data_i[g*W +: W];
      else if (we_i && (waddr_i == AW'(g)))         q <= wdata_i;
    end
    assign regs_o[g*W +: W] = q;
  end

  AST_NO_LOAD_WRITE_MIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !we_i); // R4
endmodule

// File: rtl/mt_exec.sv
module mt_exec
  import mt_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG*W-1:0] regs_i,
  input  logic              en_i,
  input  op_e               code_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [W-1:0]      imm_i,
  input  logic [W-1:0]      upset_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [W-1:0]      wdata_o
);
  logic [W-1:0] old_val;
  logic [W-1:0] res;

  always_comb begin
    old_val = '0;
    for (int i = 0; i < NREG; i++)
      if (dst_i == AW'(i)) old_val = regs_i[i*W +: W];
  end

  always_comb begin
    unique case (code_i)
      OP_LDI:  res = imm_i;
      OP_ADDI: res = old_val + imm_i;
      OP_XORI: res = old_val ^ imm_i;
      default: res = old_val;
    endcase
  end

  assign we_o    = en_i && (code_i != OP_NOP);
  assign waddr_o = dst_i;
  assign wdata_o = res ^ upset_i;
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import mt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  err_i,
  input  logic  err_persist_i,
  output mode_e mode_o,
  output logic  ready_o,
  output logic  busy_o,
  output logic  takeover_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_RUN:    if (err_i) mode_d = err_persist_i ? MD_TAKEN : MD_REPLAY;
      MD_REPLAY: mode_d = MD_VERIFY;
      MD_VERIFY: mode_d = err_i ? MD_TAKEN : MD_RUN;
      default:   mode_d = MD_TAKEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MD_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o     = mode_q;
  assign busy_o     = (mode_q == MD_REPLAY) || (mode_q == MD_VERIFY);
  assign takeover_o = (mode_q == MD_TAKEN);
  assign ready_o    = ((mode_q == MD_RUN) && !err_i) || (mode_q == MD_TAKEN);

  AST_BUSY_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mode_q == MD_REPLAY)); // R4
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_VERIFY) |=> !busy_o); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o); // R5
  AST_RECUR_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$rose(busy_o) && err_i) |=> takeover_o); // R6
  AST_PERSIST_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_RUN) && err_i && err_persist_i) |=> (takeover_o && !busy_o)); // R7
  AST_TAKEOVER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_o |=> (takeover_o && ready_o)); // R8
endmodule

// File: rtl/mt_recovery.sv
module mt_recovery
  import mt_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [AW-1:0]     op_dst_i,
  input  logic [W-1:0]      op_imm_i,
  output logic              op_ready_o,
  input  logic              err_i,
  input  logic              err_persist_i,
  input  logic [W-1:0]      upset_i,
  output logic              active_sel_o,
  output logic [NREG*W-1:0] state_o,
  output logic              busy_o,
  output logic              takeover_o
);
  mode_e mode;
  logic  run, rep, ver, tak, acc;

  // one-cycle lag register feeding the shadow copy
  logic          p_valid;
  op_e           p_code;
  logic [AW-1:0] p_dst;
  logic [W-1:0]  p_imm;

  logic [NREG*W-1:0] m_regs, t_regs;
  logic              m_restore, m_en, t_en;
  op_e               m_code, t_code;
  logic [AW-1:0]     m_dst, t_dst;
  logic [W-1:0]      m_imm, t_imm;
  logic              m_we, t_we;
  logic [AW-1:0]     m_waddr, t_waddr;
  logic [W-1:0]      m_wdata, t_wdata;

  mt_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .err_i         (err_i),
    .err_persist_i (err_persist_i),
    .mode_o        (mode),
    .ready_o       (op_ready_o),
    .busy_o        (busy_o),
    .takeover_o    (takeover_o)
  );

  assign run = (mode == MD_RUN);
  assign rep = (mode == MD_REPLAY);
  assign ver = (mode == MD_VERIFY);
  assign tak = (mode == MD_TAKEN);
  assign acc = op_valid_i && op_ready_o;

  always_comb begin
    m_restore = run && err_i && !err_persist_i;
    m_en      = (run && acc) || (rep && p_valid);
    m_code    = rep ? p_code : op_e'(op_code_i);
    m_dst     = rep ? p_dst  : op_dst_i;
    m_imm     = rep ? p_imm  : op_imm_i;
    t_en      = (run && !m_restore && p_valid) || (ver && p_valid) || (tak && acc);
    t_code    = tak ? op_e'(op_code_i) : p_code;
    t_dst     = tak ? op_dst_i : p_dst;
    t_imm     = tak ? op_imm_i : p_imm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid <= 1'b0;
      p_code  <= OP_NOP;
      p_dst   <= '0;
      p_imm   <= '0;
    end else if (run && !err_i) begin
      p_valid <= acc;
      p_code  <= op_e'(op_code_i);
      p_dst   <= op_dst_i;
      p_imm   <= op_imm_i;
    end else if (!(m_restore || rep)) begin
      p_valid <= 1'b0;
    end
  end

  mt_exec #(.W(W), .NREG(NREG)) u_m_exec (
    .regs_i  (m_regs),
    .en_i    (m_en),
    .code_i  (m_code),
    .dst_i   (m_dst),
    .imm_i   (m_imm),
    .upset_i (upset_i),
    .we_o    (m_we),
    .waddr_o (m_waddr),
    .wdata_o (m_wdata)
  );

  mt_exec #(.W(W), .NREG(NREG)) u_t_exec (
    .regs_i  (t_regs),
    .en_i    (t_en),
    .code_i  (t_code),
    .dst_i   (t_dst),
    .imm_i   (t_imm),
    .upset_i ({W{1'b0}}),
    .we_o    (t_we),
    .waddr_o (t_waddr),
    .wdata_o (t_wdata)
  );

  mt_regbank #(.W(W), .NREG(NREG)) u_m_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (m_we),
    .waddr_i     (m_waddr),
    .wdata_i     (m_wdata),
    .load_i      (m_restore),
    .load_data_i (t_regs),
    .regs_o      (m_regs)
  );

  mt_regbank #(.W(W), .NREG(NREG)) u_t_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (t_we),
    .waddr_i     (t_waddr),
    .wdata_i     (t_wdata),
    .load_i      (1'b0),
    .load_data_i ({NREG*W{1'b0}}),
    .regs_o      (t_regs)
  );

  assign active_sel_o = tak;
  assign state_o      = tak ? t_regs : m_regs;

  AST_RESTORE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_restore |=> (m_regs == $past(t_regs))); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep |=> $stable(t_regs)); // R4
  AST_PRIMARY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_o |=> $stable(m_regs)); // R8
  AST_SELECT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_sel_o == takeover_o); // R8
endmodule

// File: tb/mt_recovery_test.sv
module mt_recovery_test;
  localparam int W = 8;
  localparam int NREG = 4;
  localparam int AW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic op_valid_i = 1'b0;
  logic [1:0] op_code_i = '0;
  logic [AW-1:0] op_dst_i = '0;
  logic [W-1:0] op_imm_i = '0;
  logic err_i = 1'b0;
  logic err_persist_i = 1'b0;
  logic [W-1:0] upset_i = '0;
  logic op_ready_o, active_sel_o, busy_o, takeover_o;
  logic [NREG*W-1:0] state_o;

  always #10 clk_i = ~clk_i;

  mt_recovery #(.W(W), .NREG(NREG)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .op_dst_i(op_dst_i), .op_imm_i(op_imm_i), .op_ready_o(op_ready_o), .err_i(err_i),
    .err_persist_i(err_persist_i), .upset_i(upset_i), .active_sel_o(active_sel_o),
    .state_o(state_o), .busy_o(busy_o), .takeover_o(takeover_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] g [NREG];
  int md;        // 0 run, 1 replay, 2 verify, 3 taken
  bit pend_err;
  int n_recur = 0, n_persist = 0, n_transient = 0, n_ign = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] apply_op(input logic [1:0] c, input logic [W-1:0] o,
                                            input logic [W-1:0] imm);
    case (c)
      2'd1: return imm;
      2'd2: return o + imm;
      2'd3: return o ^ imm;
      default: return o;
    endcase
  endfunction

  function automatic logic [NREG*W-1:0] gold_vec();
    logic [NREG*W-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*W +: W] = g[i];
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    op_valid_i = 0; err_i = 0; err_persist_i = 0; upset_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NREG; i++) g[i] = '0;
    md = 0; pend_err = 0;
    #1;
    chk(state_o == '0, "R1", "state after reset", 64'(state_o), 0);
    chk(!busy_o && !takeover_o && !active_sel_o, "R1", "flags after reset",
        {busy_o, takeover_o, active_sel_o}, 0);
    chk(op_ready_o, "R1", "ready after reset", 64'(op_ready_o), 1);
  endtask

  task automatic episode(input bit allow_perm, input int max_cyc);
    int taken_cyc = 0;
    bit exp_ready, exp_busy, acc;
    for (int c = 0; c < max_cyc && taken_cyc < 60; c++) begin
      @(negedge clk_i);
      err_i = pend_err; pend_err = 0; err_persist_i = 0; upset_i = '0;
      op_valid_i = ($urandom % 4) != 0;
      op_code_i = 2'($urandom);
      op_dst_i = AW'($urandom);
      op_imm_i = W'($urandom);
      if (md == 0 && err_i)
        err_persist_i = allow_perm && ($urandom % 4 == 0);
      else if (md == 0 && op_valid_i && op_code_i != 2'd0 && ($urandom % 8 == 0))
        upset_i = W'($urandom % 255 + 1);
      else if (md == 1 && allow_perm && ($urandom % 3 == 0)) begin
        upset_i = W'($urandom % 255 + 1);
        pend_err = 1;
      end else if (md == 3) begin
        err_i = $urandom % 2;
        err_persist_i = $urandom % 2;
        upset_i = W'($urandom);
        if (err_i || upset_i != 0) n_ign++;
      end
      #1;
      exp_ready = (md == 0 && !err_i) || md == 3;
      exp_busy  = (md == 1 || md == 2);
      chk(op_ready_o == exp_ready, "R5", "ready", 64'(op_ready_o), 64'(exp_ready));
      chk(busy_o == exp_busy, "R4", "busy", 64'(busy_o), 64'(exp_busy));
      chk(takeover_o == (md == 3), (md == 3) ? "R8" : "R6", "takeover",
          64'(takeover_o), 64'(md == 3));
      chk(active_sel_o == (md == 3), "R8", "active select", 64'(active_sel_o), 64'(md == 3));
      if ((md == 0 && !err_i) || md == 3)
        chk(state_o == gold_vec(), (md == 3) ? "R3" : "R2", "state",
            64'(state_o), 64'(gold_vec()));
      acc = op_valid_i && exp_ready;
      if (acc) begin
        g[op_dst_i] = apply_op(op_code_i, g[op_dst_i], op_imm_i);
        if (md == 0 && upset_i != 0) pend_err = 1;
      end
      case (md)
        0: if (err_i) begin
             if (err_persist_i) begin md = 3; n_persist++; end
             else begin md = 1; n_transient++; end
           end
        1: md = 2;
        2: if (err_i) begin md = 3; n_recur++; end else md = 0;
        default: begin md = 3; taken_cyc++; end
      endcase
    end
  endtask

  // directed: persistent fault on the very first operation, in-flight op must survive
  task automatic directed_persist();
    do_reset();
    @(negedge clk_i);
    op_valid_i = 1; op_code_i = 2'd1; op_dst_i = 2'd3; op_imm_i = 8'hA5; upset_i = 8'h0F;
    @(negedge clk_i);
    op_valid_i = 0; upset_i = '0; err_i = 1; err_persist_i = 1;
    #1;
    chk(!op_ready_o, "R5", "ready low on error", 64'(op_ready_o), 0);
    @(negedge clk_i);
    err_i = 0; err_persist_i = 0;
    #1;
    chk(takeover_o && !busy_o, "R7", "takeover next cycle", {takeover_o, busy_o}, 2'b10);
    chk(state_o[3*W +: W] == 8'hA5, "R3", "in-flight op kept", 64'(state_o[3*W +: W]), 8'hA5);
    n_persist++;
  endtask

  // directed: transient fault, two busy cycles, held op accepted afterwards
  task automatic directed_transient();
    do_reset();
    @(negedge clk_i);
    op_valid_i = 1; op_code_i = 2'd1; op_dst_i = 2'd1; op_imm_i = 8'hFF;
    @(negedge clk_i);
    op_code_i = 2'd2; op_imm_i = 8'h02; upset_i = 8'h80;
    @(negedge clk_i);
    upset_i = '0; err_i = 1; op_code_i = 2'd3; op_imm_i = 8'h11;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      err_i = 0;
      #1;
      chk(busy_o && !op_ready_o, "R4", "busy cycle", {busy_o, op_ready_o}, 2'b10);
    end
    @(negedge clk_i);
    #1;
    chk(!busy_o && op_ready_o, "R5", "resume", {busy_o, op_ready_o}, 2'b01);
    chk(state_o[1*W +: W] == 8'h01, "R4", "restored and replayed",
        64'(state_o[1*W +: W]), 8'h01);
    @(negedge clk_i);
    op_valid_i = 0;
    #1;
    chk(state_o[1*W +: W] == 8'h10, "R5", "held op applied", 64'(state_o[1*W +: W]), 8'h10);
  endtask

  initial begin
    md = 0; pend_err = 0;
    process::self().srandom(32'd1234);
    directed_persist();
    directed_transient();
    do_reset();
    episode(1'b0, 3000);
    for (int e = 0; e < 40; e++) begin
      do_reset();
      episode(1'b1, 1500);
    end
    chk(n_recur > 0, "R6", "recurrence reached", 64'(n_recur), 1);
    chk(n_persist > 1, "R7", "persistent reached", 64'(n_persist), 2);
    chk(n_transient > 0, "R4", "transient reached", 64'(n_transient), 1);
    chk(n_ign > 0, "R8", "ignored inputs reached", 64'(n_ign), 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule